// File: doc/BRIEF.md
# Converter Serial Read Controller

This block is the host side of a link to a 16-bit successive-approximation converter. The converter is wired in a three-wire chip-select arrangement with no busy flag, and its data-input pin is tied high. A single strobe output does two jobs: its rising edge starts a conversion, and its low level selects the converter for readout. The block also drives the serial clock and samples the serial data line. All timing is counted in system clocks and set by parameters.

When a request arrives, the controller raises the strobe and holds it high for the worst-case conversion time. This keeps the converter from ever producing a busy indication. The controller then lowers the strobe, and the converter puts its most significant bit on the line at once. The controller samples that bit, then issues 15 clock pulses and samples one more bit after each falling edge. After the last sample it presents the assembled word with a one-cycle valid pulse. The strobe stays low until the next request arrives.

Top module: `adc_serial_reader`

## Requirements
- R1: While `rst` is high at a clock edge, the controller goes idle after that edge: `cnv`, `sck`, `busy` and `data_valid` are all low.
- R2: A `start` sampled high while idle raises `cnv` and `busy` after that edge. `cnv` then stays high for exactly CONV_MAX_CYCLES cycles.
- R3: `sck` is low in every cycle in which `cnv` is high.
- R4: After `cnv` falls, `sck` stays low for SCK_HALF_CYCLES cycles. It then makes exactly 15 pulses, each high for SCK_HALF_CYCLES cycles and low for SCK_HALF_CYCLES cycles, and then stays low.
- R5: `sdo` is sampled in the last cycle of each of the 16 low phases of `sck` that follow the fall of `cnv`. The first sample becomes bit 15 of `data` and the last becomes bit 0.
- R6: In the cycle after the 16th sample, `data_valid` is high for exactly one cycle with the word on `data`. `busy` is low in that cycle, and `cnv` stays low until a new request is accepted.
- R7: A `start` sampled while `busy` is high is ignored: the strobe, clock, valid and busy waveforms are the same as if it had never arrived.
- R8: A `start` sampled in the `data_valid` cycle is accepted and begins a new conversion at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one conversion and readout |
| sdo | input | 1 | Serial data line from the converter |
| cnv | output | 1 | Convert strobe / converter select |
| sck | output | 1 | Serial clock to the converter |
| busy | output | 1 | High while a conversion or readout is in progress |
| data_valid | output | 1 | One-cycle pulse marking a new word |
| data | output | 16 | Last word read, most significant bit first on the line |

## Verification
Some rules hold cycle by cycle, and the assertions check them on every cycle: the clock is quiet while the strobe is high, the strobe rises only on an accepted request, the valid pulse lasts one cycle and never coincides with busy, and reset clears the outputs. Other behaviour depends on exact counts and on bit order: the strobe width, the 15 clock pulses with their phase lengths, where each bit is sampled, and that a request arriving while busy changes nothing. These only show up when the bench compares against its cycle model while a converter model shifts out known words, including all-zeros, all-ones and alternating patterns, a back-to-back request and a reset in the middle of a readout.

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int DATA_BITS       = 16,
  parameter int CONV_MAX_CYCLES = 40,
  parameter int SCK_HALF_CYCLES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 sdo,
  output logic                 cnv,
  output logic                 sck,
  output logic                 busy,
  output logic                 data_valid,
  output logic [DATA_BITS-1:0] data
);
  localparam int CMAX = (CONV_MAX_CYCLES > SCK_HALF_CYCLES) ? CONV_MAX_CYCLES : SCK_HALF_CYCLES;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int BW   = $clog2(DATA_BITS + 1);

  typedef enum logic [1:0] {IDLE, CONV, READ} state_t;

  state_t               st;
  logic [CW-1:0]        cnt;
  logic [BW-1:0]        nbits;
  logic [DATA_BITS-1:0] shreg;

  wire tick = (cnt == '0);
  wire last = (nbits == BW'(DATA_BITS - 1));
  wire [DATA_BITS-1:0] word = {shreg[DATA_BITS-2:0], sdo};

  assign busy = (st != IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= IDLE;
      cnv        <= 1'b0;
      sck        <= 1'b0;
      data_valid <= 1'b0;
      cnt        <= '0;
      nbits      <= '0;
      shreg      <= '0;
      data       <= '0;
    end else begin
      data_valid <= 1'b0;
      case (st)
        IDLE: if (start) begin
          st  <= CONV;
          cnv <= 1'b1;
          cnt <= CW'(CONV_MAX_CYCLES - 1);
        end
        CONV: if (tick) begin
          cnv   <= 1'b0;
          st    <= READ;
          cnt   <= CW'(SCK_HALF_CYCLES - 1);
          nbits <= '0;
        end else begin
          cnt <= cnt - 1'b1;
        end
        READ: if (!tick) begin
          cnt <= cnt - 1'b1;
        end else if (sck) begin
          sck <= 1'b0;
          cnt <= CW'(SCK_HALF_CYCLES - 1);
        end else begin
          shreg <= word;
          nbits <= nbits + 1'b1;
          if (last) begin
            data       <= word;
            data_valid <= 1'b1;
            st         <= IDLE;
          end else begin
            sck <= 1'b1;
            cnt <= CW'(SCK_HALF_CYCLES - 1);
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module adc_serial_reader_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic cnv,
  input logic sck,
  input logic busy,
  input logic data_valid
);
  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!cnv && !sck && !busy && !data_valid));
  // R3
  sck_quiet_chk: assert property (@(posedge clk) disable iff (rst) cnv |-> !sck);
  // R2
  cnv_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(cnv) |-> $past(start && !busy));
  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst) data_valid |=> !data_valid);
  // R6
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst) data_valid |-> (!busy && !cnv));
  // R4
  sck_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(sck) |-> (busy && !cnv));
endmodule

bind adc_serial_reader adc_serial_reader_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .cnv(cnv), .sck(sck),
  .busy(busy), .data_valid(data_valid)
);

// File: tb/adc_serial_reader_bench.sv
module adc_serial_reader_bench;
  localparam int PERIOD = 10;
  localparam int C  = 40;
  localparam int H  = 2;
  localparam int NB = 16;
  localparam int ENDN = C + (2 * NB - 1) * H;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, sdo = 1'b0;
  logic cnv, sck, busy, data_valid;
  logic [NB-1:0] data;

  always #(PERIOD/2) clk = ~clk;

  adc_serial_reader #(.DATA_BITS(NB), .CONV_MAX_CYCLES(C), .SCK_HALF_CYCLES(H)) u_adc_serial_reader (
    .clk(clk), .rst(rst), .start(start), .sdo(sdo), .cnv(cnv), .sck(sck),
    .busy(busy), .data_valid(data_valid), .data(data)
  );

  int checks = 0, errors = 0;
  bit done = 0, armed = 0;

  // reference model: n = cycles since accepted request, -1 when idle
  int n = -1;
  bit exp_valid = 0;
  logic [NB-1:0] next_word = '0, exp_word = '0;

  always @(posedge clk) begin
    if (rst) begin
      n = -1; exp_valid = 0;
    end else if (n >= 0) begin
      n++;
      exp_valid = 0;
      if (n == ENDN) begin n = -1; exp_valid = 1; end
    end else begin
      exp_valid = 0;
      if (start) begin n = 0; exp_word = next_word; end
    end
    armed = 1;
  end

  // converter model
  logic cnv_q = 0, sck_q = 0;
  logic [NB-1:0] conv_word = '0;
  int idx = 0;
  always @(negedge clk) begin
    if (cnv && !cnv_q) begin conv_word = next_word; sdo = 1'b0; end
    else if (!cnv && cnv_q) begin idx = NB - 1; sdo = conv_word[idx]; end
    else if (!cnv && !sck && sck_q) begin idx--; sdo = (idx >= 0) ? conv_word[idx] : 1'b0; end
    cnv_q = cnv; sck_q = sck;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (armed && !done) begin
    automatic bit e_cnv = (n >= 0) && (n < C);
    automatic bit e_sck = (n >= C) && ((((n - C) / H) % 2) == 1);
    chk("R2 cnv", 32'(cnv), 32'(e_cnv));
    chk("R4 sck", 32'(sck), 32'(e_sck));
    chk("R7 busy", 32'(busy), 32'(n >= 0));
    chk("R6 data_valid", 32'(data_valid), 32'(exp_valid));
    if (exp_valid) chk("R5 data", 32'(data), 32'(exp_word));
    if (cnv) chk("R3 sck low with cnv", 32'(sck), 0);
  end

  task automatic read_word(logic [NB-1:0] w);
    next_word = w;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (ENDN + 3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset cnv", 32'(cnv), 0);
    chk("R1 reset sck", 32'(sck), 0);
    chk("R1 reset busy", 32'(busy), 0);
    chk("R1 reset valid", 32'(data_valid), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    read_word(16'hA5C3);
    read_word(16'h0000);
    read_word(16'hFFFF);
    read_word(16'h8001);
    // R7: request during conversion and during readout is ignored
    next_word = 16'h5A3C;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (5) @(negedge clk);
    next_word = 16'h1234;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (C) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (ENDN) @(negedge clk);
    // R8: request in the valid cycle starts a new conversion
    next_word = 16'h6E91;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!data_valid) @(negedge clk);
    next_word = 16'hC00F;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R8 restart cnv", 32'(cnv), 1);
    repeat (ENDN + 3) @(negedge clk);
    // R1 reset in the middle of a readout
    next_word = 16'h3377;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (C + 7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk("R1 mid reset busy", 32'(busy), 0);
    chk("R1 mid reset sck", 32'(sck), 0);
    read_word(16'h0F0F);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule